// File: doc/BRIEF.md
# Flash Command Register Front End

This block is the synchronous command-register front end of a parallel flash device. The system clock samples an active-low chip enable and an active-low write strobe. A write cycle latches the address when the strobe falls and the command byte when the strobe rises. The accepted byte then becomes the command register and selects the operating mode: read, erase, program, verify, or a halted state. The memory array and the analog supply detectors sit outside the block. They supply only two flags, one saying the high programming voltage is present and one saying the core supply is above the lockout level.

Erase and program are protected by a guard timer. Accepting either command loads the timer. If no verify command arrives before the timer runs out, the operation is stopped and a timeout flag is raised. In the halted state the device waits for a verify or a reset command. While the programming voltage is missing, the command register is held at 00h, which is read mode.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After synchronous reset, `cmd_reg` is 00h, `mode` is read (0), `timeout` is 0 and `addr_lat` is 0.
- R2: The address bus is captured when the write strobe falls. A change on the address bus after the fall and before the rise does not reach `addr_lat`.
- R3: The command byte is taken from the data bus as it stands when the write strobe rises. A value present only at the fall is not stored.
- R4: A strobe cycle during which chip enable is high leaves `cmd_reg`, `mode` and `addr_lat` unchanged.
- R5: While `vdd_ok` is 0, a strobe cycle leaves `cmd_reg`, `mode` and `addr_lat` unchanged.
- R6: While `hv_ok` is 0, `cmd_reg` is 00h, `mode` is read and `timeout` is 0, and any write is ignored.
- R7: The mode encoding is read=0, erase=1, program=2, verify=3, halted=4. A write of 00h or of the reset code (default FFh) selects read. The erase code (default 20h) selects erase, the program code (default 40h) selects program and the verify code (default A0h) selects verify. Any other byte is stored in `cmd_reg` and leaves `mode` unchanged.
- R8: When erase or program is accepted and no further command arrives, `mode` stays erase or program for exactly TIMEOUT_CYC clock cycles after the cycle in which it was entered. It then becomes halted, with `timeout` at 1.
- R9: In the halted state, writes other than the verify or reset code are ignored, so `cmd_reg`, `mode` and `timeout` are unchanged. Verify moves to verify mode and reset moves to read mode, and both clear `timeout`.
- R10: A verify command accepted before the timer expires stops the timer, so verify mode stays and `timeout` stays 0.
- R11: Raising chip enable during erase or program does not end or pause the operation, and the timeout still fires on schedule.
- R12: Accepting erase or program while an operation is already running reloads the timer to the full TIMEOUT_CYC from the new acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write strobe, asynchronous to clk |
| addr_in | input | AW | Address bus |
| data_in | input | DW | Data bus carrying the command byte |
| hv_ok | input | 1 | High programming voltage present |
| vdd_ok | input | 1 | Core supply above the write lockout level |
| cmd_reg | output | DW | Current command register value |
| addr_lat | output | AW | Address captured at the last qualified strobe fall |
| mode | output | 3 | Operating mode (read=0, erase=1, program=2, verify=3, halted=4) |
| timeout | output | 1 | Guard timer stopped the last erase or program |

## Verification
Each command code is written from each relevant mode. This shows the mode decode apart from plain storage of an unknown byte, and shows that the halted state filters commands. Strobes where the address or data bus changes halfway through show which edge each bus is sampled on. Writes with chip enable high, with the supply flag low and with the programming-voltage flag low each show a separate gating path. Timed runs measure the guard window cycle by cycle. They cover an operation left alone, one closed early by verify, one with chip enable dropped, and one restarted midway, which together separate expiry, cancellation, independence from chip enable and reload.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    MODE_READ   = 3'd0,
    MODE_ERASE  = 3'd1,
    MODE_PROG   = 3'd2,
    MODE_VERIFY = 3'd3,
    MODE_HALT   = 3'd4
  } mode_t;

  function automatic logic is_busy(mode_t m);
    return (m == MODE_ERASE) || (m == MODE_PROG);
  endfunction

endpackage

// File: rtl/fc_strobe_sync.sv
module fc_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic we_n,
  input  logic ce_n,
  output logic we_fall,
  output logic we_rise,
  output logic ce_low
);

  localparam int WL = SYNC_STAGES + 1;

  logic [WL-1:0]          we_pipe;
  logic [SYNC_STAGES-1:0] ce_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_pipe <= '1;
      ce_pipe <= '1;
    end else begin
      we_pipe <= {we_pipe[WL-2:0], we_n};
      ce_pipe <= {ce_pipe[SYNC_STAGES-2:0], ce_n};
    end
  end

  // Oldest entry is the previous synchronized value.
  assign we_fall = we_pipe[WL-1] & ~we_pipe[WL-2];
  assign we_rise = ~we_pipe[WL-1] & we_pipe[WL-2];
  assign ce_low  = ~ce_pipe[SYNC_STAGES-1];

endmodule

// File: rtl/fc_cmd_capture.sv
module fc_cmd_capture #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_fall,
  input  logic          we_rise,
  input  logic          ce_low,
  input  logic          vdd_ok,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic [AW-1:0] addr_lat,
  output logic          wr_valid,
  output logic [DW-1:0] wr_byte
);

  logic armed;
  logic qual;

  assign qual = ce_low & vdd_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      addr_lat <= '0;
      wr_valid <= 1'b0;
      wr_byte  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (!qual) begin
        armed <= 1'b0;
      end else if (we_fall) begin
        armed    <= 1'b1;
        addr_lat <= addr_in;
      end else if (we_rise && armed) begin
        armed    <= 1'b0;
        wr_valid <= 1'b1;
        wr_byte  <= data_in;
      end
    end
  end

endmodule

// File: rtl/fc_guard_timer.sv
module fc_guard_timer #(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expire
);

  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(TIMEOUT_CYC);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= LOAD_VAL;
    end else if (run && cnt != '0) begin
      cnt <= cnt - ONE;
    end else if (!run) begin
      cnt <= '0;
    end
  end

  assign expire = run && !load && (cnt == ONE);

endmodule

// File: rtl/fc_mode_ctrl.sv
module fc_mode_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int              DW          = 8,
  parameter int              TIMEOUT_CYC = 64,
  parameter logic [DW-1:0]   CODE_ERASE  = 8'h20,
  parameter logic [DW-1:0]   CODE_PROG   = 8'h40,
  parameter logic [DW-1:0]   CODE_VERIFY = 8'hA0,
  parameter logic [DW-1:0]   CODE_RESET  = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hv_ok,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_byte,
  output logic [DW-1:0] cmd_q,
  output mode_t         mode_q,
  output logic          timeout_q
);

  logic  accept;
  logic  start_op;
  logic  expire;
  mode_t next_mode;

  // In the halted state only verify and reset get through.
  always_comb begin
    if (!hv_ok)
      accept = 1'b0;
    else if (mode_q == MODE_HALT)
      accept = wr_valid && (wr_byte == CODE_VERIFY || wr_byte == CODE_RESET);
    else
      accept = wr_valid;
  end

  always_comb begin
    next_mode = mode_q;
    if (wr_byte == '0 || wr_byte == CODE_RESET) next_mode = MODE_READ;
    else if (wr_byte == CODE_ERASE)             next_mode = MODE_ERASE;
    else if (wr_byte == CODE_PROG)              next_mode = MODE_PROG;
    else if (wr_byte == CODE_VERIFY)            next_mode = MODE_VERIFY;
  end

  assign start_op = accept && is_busy(next_mode);

  fc_guard_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (start_op),
    .run    (is_busy(mode_q) && hv_ok),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (rst || !hv_ok) begin
      cmd_q     <= '0;
      mode_q    <= MODE_READ;
      timeout_q <= 1'b0;
    end else if (accept) begin
      cmd_q     <= wr_byte;
      mode_q    <= next_mode;
      timeout_q <= 1'b0;
    end else if (expire) begin
      mode_q    <= MODE_HALT;
      timeout_q <= 1'b1;
    end
  end

endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend #(
  parameter int            AW          = 17,
  parameter int            DW          = 8,
  parameter int            SYNC_STAGES = 2,
  parameter int            TIMEOUT_CYC = 64,
  parameter logic [DW-1:0] CODE_ERASE  = 8'h20,
  parameter logic [DW-1:0] CODE_PROG   = 8'h40,
  parameter logic [DW-1:0] CODE_VERIFY = 8'hA0,
  parameter logic [DW-1:0] CODE_RESET  = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic          hv_ok,
  input  logic          vdd_ok,
  output logic [DW-1:0] cmd_reg,
  output logic [AW-1:0] addr_lat,
  output logic [2:0]    mode,
  output logic          timeout
);

  import flash_cmd_pkg::*;

  logic          we_fall, we_rise, ce_low;
  logic          wr_valid;
  logic [DW-1:0] wr_byte;
  mode_t         mode_q;

  fc_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .we_n    (we_n),
    .ce_n    (ce_n),
    .we_fall (we_fall),
    .we_rise (we_rise),
    .ce_low  (ce_low)
  );

  fc_cmd_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .we_fall  (we_fall),
    .we_rise  (we_rise),
    .ce_low   (ce_low),
    .vdd_ok   (vdd_ok),
    .addr_in  (addr_in),
    .data_in  (data_in),
    .addr_lat (addr_lat),
    .wr_valid (wr_valid),
    .wr_byte  (wr_byte)
  );

  fc_mode_ctrl #(
    .DW          (DW),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CODE_ERASE  (CODE_ERASE),
    .CODE_PROG   (CODE_PROG),
    .CODE_VERIFY (CODE_VERIFY),
    .CODE_RESET  (CODE_RESET)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .hv_ok     (hv_ok),
    .wr_valid  (wr_valid),
    .wr_byte   (wr_byte),
    .cmd_q     (cmd_reg),
    .mode_q    (mode_q),
    .timeout_q (timeout)
  );

  assign mode = mode_q;

endmodule

// File: rtl/flash_cmd_frontend_chk.sv
module flash_cmd_frontend_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          hv_ok,
  input logic          vdd_ok,
  input logic [DW-1:0] cmd_reg,
  input logic [2:0]    mode,
  input logic          timeout
);

  p_hv_forces_read_r6: assert property (@(posedge clk) disable iff (rst)
    !hv_ok |=> (cmd_reg == '0 && mode == 3'd0 && !timeout));

  p_lockout_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (hv_ok && !vdd_ok && !$past(vdd_ok)) |=> $stable(cmd_reg));

  p_mode_legal_r7: assert property (@(posedge clk) disable iff (rst)
    mode <= 3'd4);

  p_timeout_only_halted_r8: assert property (@(posedge clk) disable iff (rst)
    timeout |-> mode == 3'd4);

  p_halt_from_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (mode != 3'd4) ##1 (mode == 3'd4) |-> ($past(mode) == 3'd1 || $past(mode) == 3'd2));

  p_halt_exit_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd4) ##1 (mode != 3'd4) |-> (mode == 3'd3 || mode == 3'd0) && !timeout);

endmodule

bind flash_cmd_frontend flash_cmd_frontend_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .hv_ok   (hv_ok),
  .vdd_ok  (vdd_ok),
  .cmd_reg (cmd_reg),
  .mode    (mode),
  .timeout (timeout)
);

// File: tb/flash_cmd_frontend_test.sv
`timescale 1ns/1ps
module flash_cmd_frontend_test;

  localparam int AW = 17;
  localparam int DW = 8;
  localparam int T  = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, we_n = 1'b1, hv_ok = 1'b1, vdd_ok = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic [DW-1:0] cmd_reg;
  logic [AW-1:0] addr_lat;
  logic [2:0]    mode;
  logic          timeout;

  always #2.5 clk = ~clk;

  flash_cmd_frontend #(.AW(AW), .DW(DW), .TIMEOUT_CYC(T)) uut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr_in(addr_in),
    .data_in(data_in), .hv_ok(hv_ok), .vdd_ok(vdd_ok), .cmd_reg(cmd_reg),
    .addr_lat(addr_lat), .mode(mode), .timeout(timeout)
  );

  typedef struct {
    logic [DW-1:0] cmd;
    logic [2:0]    md;
    logic          to;
    logic [AW-1:0] ad;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // Driver side of the scoreboard: queue the expected state.
  task automatic expect_state(string tag, logic [DW-1:0] c, logic [2:0] m,
                              logic t, logic [AW-1:0] a);
    exp_t e;
    e.cmd = c; e.md = m; e.to = t; e.ad = a; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares queued items a little after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " cmd_reg"}, 32'(cmd_reg), 32'(e.cmd));
        chk({e.tag, " mode"}, 32'(mode), 32'(e.md));
        chk({e.tag, " timeout"}, 32'(timeout), 32'(e.to));
        chk({e.tag, " addr_lat"}, 32'(addr_lat), 32'(e.ad));
      end
    end
  end

  // Strobe cycle; a2/d2 replace a1/d1 halfway through the low phase.
  task automatic issue(logic ce, logic [AW-1:0] a1, logic [DW-1:0] d1,
                       logic [AW-1:0] a2, logic [DW-1:0] d2);
    @(negedge clk);
    ce_n = ce; addr_in = a1; data_in = d1;
    @(negedge clk);
    we_n = 1'b0;
    repeat (5) @(negedge clk);
    addr_in = a2; data_in = d2;
    repeat (5) @(negedge clk);
    we_n = 1'b1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    issue(1'b0, a, d, a, d);
    repeat (6) @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic wait_mode(logic [2:0] m);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (mode == m) return;
    end
    chk("wait_mode reached", 32'(mode), 32'(m));
  endtask

  // Holds for T-1 further cycles, then halted on the next.
  task automatic time_window(string tag, logic [2:0] m);
    repeat (T - 1) @(negedge clk);
    chk({tag, " still busy at T-1"}, 32'(mode), 32'(m));
    @(negedge clk);
    chk({tag, " halted at T"}, 32'(mode), 32'd4);
    chk({tag, " timeout at T"}, 32'(timeout), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_state("R1 reset", 8'h00, 3'd0, 1'b0, '0);
    @(negedge clk);

    // R7 decode of every code
    wr(17'h01234, 8'h20); expect_state("R7 erase", 8'h20, 3'd1, 1'b0, 17'h01234);
    wr(17'h01234, 8'hA0); expect_state("R7 verify", 8'hA0, 3'd3, 1'b0, 17'h01234);
    wr(17'h00010, 8'hFF); expect_state("R7 reset", 8'hFF, 3'd0, 1'b0, 17'h00010);
    wr(17'h00011, 8'h40); expect_state("R7 program", 8'h40, 3'd2, 1'b0, 17'h00011);
    wr(17'h00012, 8'h00); expect_state("R7 zero read", 8'h00, 3'd0, 1'b0, 17'h00012);
    wr(17'h00013, 8'h55); expect_state("R7 unknown", 8'h55, 3'd0, 1'b0, 17'h00013);

    // R2 address at fall, R3 data at rise
    issue(1'b0, 17'h00AAA, 8'h40, 17'h00555, 8'h40);
    repeat (6) @(negedge clk); ce_n = 1'b1;
    expect_state("R2 addr at fall", 8'h40, 3'd2, 1'b0, 17'h00AAA);
    issue(1'b0, 17'h00100, 8'h55, 17'h00100, 8'hA0);
    repeat (6) @(negedge clk); ce_n = 1'b1;
    expect_state("R3 data at rise", 8'hA0, 3'd3, 1'b0, 17'h00100);
    wr(17'h00101, 8'hFF); expect_state("R7 reset again", 8'hFF, 3'd0, 1'b0, 17'h00101);

    // R4 chip enable high
    issue(1'b1, 17'h00007, 8'h20, 17'h00007, 8'h20);
    repeat (6) @(negedge clk);
    expect_state("R4 ce high ignored", 8'hFF, 3'd0, 1'b0, 17'h00101);

    // R5 supply lockout
    vdd_ok = 1'b0;
    wr(17'h00033, 8'h40);
    expect_state("R5 lockout ignored", 8'hFF, 3'd0, 1'b0, 17'h00101);
    vdd_ok = 1'b1;

    // R6 programming voltage absent
    wr(17'h00044, 8'h20); expect_state("R6 erase before drop", 8'h20, 3'd1, 1'b0, 17'h00044);
    hv_ok = 1'b0;
    repeat (2) @(negedge clk);
    expect_state("R6 forced read", 8'h00, 3'd0, 1'b0, 17'h00044);
    wr(17'h00045, 8'h40);
    expect_state("R6 write ignored", 8'h00, 3'd0, 1'b0, 17'h00045);
    hv_ok = 1'b1;
    @(negedge clk);

    // R8 + R11 expiry with chip deselected during the operation
    issue(1'b0, 17'h00050, 8'h20, 17'h00050, 8'h20);
    wait_mode(3'd1);
    ce_n = 1'b1;
    time_window("R8 R11 erase", 3'd1);

    // R9 halted filtering
    wr(17'h00051, 8'h40);
    expect_state("R9 program ignored in halt", 8'h20, 3'd4, 1'b1, 17'h00051);
    wr(17'h00052, 8'h00);
    expect_state("R9 zero ignored in halt", 8'h20, 3'd4, 1'b1, 17'h00052);
    wr(17'h00053, 8'hA0);
    expect_state("R9 verify exits halt", 8'hA0, 3'd3, 1'b0, 17'h00053);
    wr(17'h00054, 8'h40);
    repeat (T + 4) @(negedge clk);
    expect_state("R8 program expiry", 8'h40, 3'd4, 1'b1, 17'h00054);
    wr(17'h00055, 8'hFF);
    expect_state("R9 reset exits halt", 8'hFF, 3'd0, 1'b0, 17'h00055);

    // R10 verify in time stops the timer
    wr(17'h00060, 8'h40);
    wr(17'h00061, 8'hA0);
    repeat (T + 10) @(negedge clk);
    expect_state("R10 verify holds", 8'hA0, 3'd3, 1'b0, 17'h00061);
    wr(17'h00062, 8'hFF);

    // R12 reload on a second start
    issue(1'b0, 17'h00070, 8'h20, 17'h00070, 8'h20);
    wait_mode(3'd1);
    ce_n = 1'b1;
    repeat (T / 2) @(negedge clk);
    issue(1'b0, 17'h00071, 8'h40, 17'h00071, 8'h40);
    wait_mode(3'd2);
    ce_n = 1'b1;
    time_window("R12 reloaded", 3'd2);

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule